// File: doc/BRIEF.md
# APB Byte-Buffered Serial Port

This block is a serial port that sits on an APB bus and moves one byte at a time in each direction. Software writes a byte into a single transmit holding register. The block sends it as an 8N1 frame on `txd` once transmission is enabled and the baud divisor is valid. A frame arriving on `rxd` is sampled and placed into a single receive holding register. Software then reads it from the data offset.

Status flags report whether each holding register is full, and whether either direction was overrun. An overrun is a write to a full transmit buffer, or a frame that lands while the receive buffer still holds an unread byte. Four interrupt lines and one combined line are driven from an interrupt-status word:
- The transmit-done and receive bits latch, and are cleared by writing ones.
- The two overrun bits are the live AND of the overrun flags and their enables. Clearing an overrun bit in the interrupt-status word also clears the matching status flag.

Each bit of a frame lasts BAUDDIV clock cycles. The frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Twelve read-only identification words sit at the top of the 4 KiB window.

Top module: `apb_byte_uart`

## Requirements
- R1: After reset, the words at offsets 0x00, 0x04, 0x08, 0x0C and 0x10 all read zero, `txd` is high and all five interrupt outputs are low.
- R2: A write to the control word at 0x08 keeps only bits [6:0]. Bit 0 enables transmit, bit 1 enables receive, bit 2 enables the transmit-done interrupt, bit 3 enables the receive interrupt, bit 4 enables the transmit-overrun interrupt and bit 5 enables the receive-overrun interrupt.
- R3: Word offsets 0xFD0 to 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to these offsets have no effect. Unmapped offsets read zero.
- R4: The divisor word at 0x10 keeps the low 20 bits of a write.
- R5: Writing the data word at 0x00 while status bit 0 (transmit full, in the status word at 0x04) is clear stores the byte and sets that bit. With transmit enabled and a valid divisor, the byte is sent as start bit 0, data LSB first, then stop bit 1, each bit lasting BAUDDIV cycles. Status bit 0 clears when the stop bit ends.
- R6: Writing the data word while status bit 0 is set sets status bit 2 (transmit overrun). The byte already pending is still the one that is sent.
- R7: While the divisor is below 16, no frame starts and `txd` stays high. A byte already pending is sent once a valid divisor is written.
- R8: While receive is enabled, a received frame sets status bit 1 (receive full). Reading the data word returns the received byte in bits [7:0] and clears status bit 1.
- R9: A frame received while status bit 1 is already set sets status bit 3 (receive overrun). The data word then holds the newer byte.
- R10: A frame that completes while receive is disabled is ignored: status bit 1 stays clear.
- R11: Interrupt-status bit 0 sets at the end of a sent frame only if control bit 2 is set. Bit 1 sets on an accepted frame only if control bit 3 is set. Writing ones to these bits at 0x0C clears them. `irq_any` is the OR of the four individual lines.
- R12: Interrupt-status bits 2 and 3 equal status bits 2 and 3 ANDed with control bits 4 and 5. Writing 1 to interrupt-status bit 2 or 3 clears the matching status overrun flag.
- R13: Writing 1 to status bit 2 or 3 clears the matching overrun flag. Zeros leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and baud clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high, no wait states |
| pslverr | output | 1 | Always low |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx_ovr | output | 1 | Transmit-overrun interrupt |
| irq_rx_ovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of the four interrupt lines |

## Verification
The hardest state to reach is a transmit overrun that is still pending. The overrun write has to land while a byte waits in the holding register, and that byte must not be lost. The bench gets there by writing two bytes while transmit is disabled, or while the divisor is invalid. It then toggles the overrun enable to see the interrupt bit follow the flag, clears the flag through the interrupt-status word, and only then enables transmit to prove that the first byte is the one on the line. Receive overrun is reached by driving two frames back to back on `rxd` without reading in between.

// File: rtl/ubu_pkg.sv
package ubu_pkg;
  localparam int DATA_W  = 8;
  localparam int DIV_W   = 20;
  localparam int MIN_DIV = 16;
  localparam int ID_CNT  = 12;

  typedef struct packed {
    logic              txGo;
    logic              rxArm;
    logic [DATA_W-1:0] txByte;
  } dpCmd_t;

  typedef struct packed {
    logic              txBusy;
    logic              txDone;
    logic              rxValid;
    logic [DATA_W-1:0] rxByte;
  } dpEvt_t;

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    case (idx)
      4'd0:    idByte = 8'h04;
      4'd4:    idByte = 8'h21;
      4'd5:    idByte = 8'hB8;
      4'd6:    idByte = 8'h1B;
      4'd8:    idByte = 8'h0D;
      4'd9:    idByte = 8'hF0;
      4'd10:   idByte = 8'h05;
      4'd11:   idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ubu_regs.sv
module ubu_regs
  import ubu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  input  dpEvt_t              evt,
  output dpCmd_t              cmd,
  output logic [DIV_W-1:0]    divisor,
  output logic [3:0]          stateBits,
  output logic [6:0]          ctrlBits,
  output logic [3:0]          intBits
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int ID_BASE = (1 << WORD_W) - ID_CNT;

  logic [WORD_W-1:0] word;
  logic access, wr, rd;
  logic isData, isState, isCtrl, isInt, isBaud, isId;
  logic [WORD_W-1:0] idOff;

  logic txFull, rxFull, txOvr, rxOvr, intTx, intRx;
  logic [6:0] ctrlQ;
  logic [DIV_W-1:0] divQ;
  logic [DATA_W-1:0] txBuf, rxBuf;
  logic baudOk;

  assign word    = paddr[ADDR_W-1:2];
  assign access  = psel & penable;
  assign wr      = access & pwrite;
  assign rd      = access & ~pwrite;
  assign isData  = (word == WORD_W'(0));
  assign isState = (word == WORD_W'(1));
  assign isCtrl  = (word == WORD_W'(2));
  assign isInt   = (word == WORD_W'(3));
  assign isBaud  = (word == WORD_W'(4));
  assign isId    = (word >= WORD_W'(ID_BASE));
  assign idOff   = word - WORD_W'(ID_BASE);
  assign baudOk  = (divQ >= DIV_W'(MIN_DIV));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull <= 1'b0; rxFull <= 1'b0; txOvr <= 1'b0; rxOvr <= 1'b0;
      intTx  <= 1'b0; intRx  <= 1'b0;
      ctrlQ  <= '0;   divQ   <= '0;  txBuf <= '0;  rxBuf <= '0;
    end else begin
      if (evt.txDone) txFull <= 1'b0;
      if (wr && isData) begin
        if (txFull) txOvr <= 1'b1;
        else begin
          txFull <= 1'b1;
          txBuf  <= pwdata[DATA_W-1:0];
        end
      end
      if (wr && isState) begin
        if (pwdata[2]) txOvr <= 1'b0;
        if (pwdata[3]) rxOvr <= 1'b0;
      end
      if (wr && isInt) begin
        if (pwdata[0]) intTx <= 1'b0;
        if (pwdata[1]) intRx <= 1'b0;
        if (pwdata[2]) txOvr <= 1'b0;
        if (pwdata[3]) rxOvr <= 1'b0;
      end
      if (wr && isCtrl) ctrlQ <= pwdata[6:0];
      if (wr && isBaud) divQ  <= pwdata[DIV_W-1:0];
      if (rd && isData) rxFull <= 1'b0;
      if (evt.txDone && ctrlQ[2]) intTx <= 1'b1;
      if (evt.rxValid && ctrlQ[1]) begin
        if (rxFull) rxOvr <= 1'b1;
        rxBuf  <= evt.rxByte;
        rxFull <= 1'b1;
        if (ctrlQ[3]) intRx <= 1'b1;
      end
    end
  end

  assign stateBits = {rxOvr, txOvr, rxFull, txFull};
  assign ctrlBits  = ctrlQ;
  assign intBits   = {rxOvr & ctrlQ[5], txOvr & ctrlQ[4], intRx, intTx};
  assign divisor   = divQ;

  assign cmd.txGo   = txFull & ctrlQ[0] & baudOk & ~evt.txBusy;
  assign cmd.rxArm  = ctrlQ[1] & baudOk;
  assign cmd.txByte = txBuf;

  always_comb begin
    prdata = '0;
    if (isData)       prdata[DATA_W-1:0] = rxBuf;
    else if (isState) prdata[3:0] = stateBits;
    else if (isCtrl)  prdata[6:0] = ctrlQ;
    else if (isInt)   prdata[3:0] = intBits;
    else if (isBaud)  prdata[DIV_W-1:0] = divQ;
    else if (isId)    prdata[7:0] = idByte(idOff[3:0]);
  end
endmodule

// File: rtl/ubu_dp.sv
module ubu_dp
  import ubu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxd,
  output logic             txd,
  output dpEvt_t           evt
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);

  // transmit shifter
  logic                  txBusy;
  logic [FRAME_BITS-1:0] txShift;
  logic [BIT_W-1:0]      txBit;
  logic [DIV_W-1:0]      txCnt, txDiv;
  logic                  txBitEnd;

  assign txBitEnd = txBusy && (txCnt == txDiv - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0; txShift <= '1; txBit <= '0; txCnt <= '0; txDiv <= '0;
    end else if (!txBusy) begin
      if (cmd.txGo) begin
        txBusy  <= 1'b1;
        txShift <= {1'b1, cmd.txByte, 1'b0};
        txBit   <= '0;
        txCnt   <= '0;
        txDiv   <= divisor;
      end
    end else if (txBitEnd) begin
      txCnt <= '0;
      if (txBit == BIT_W'(FRAME_BITS - 1)) txBusy <= 1'b0;
      else begin
        txBit   <= txBit + 1'b1;
        txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
      end
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  assign txd        = txBusy ? txShift[0] : 1'b1;
  assign evt.txBusy = txBusy;
  assign evt.txDone = txBitEnd && (txBit == BIT_W'(FRAME_BITS - 1));

  // receive sampler
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxSt_t;
  rxSt_t             rxSt;
  logic [1:0]        rxSync;
  logic              rxPrev;
  logic [DIV_W-1:0]  rxCnt, rxDiv;
  logic [BIT_W-1:0]  rxBit;
  logic [DATA_W-1:0] rxShift;
  logic              rxValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11; rxPrev <= 1'b1; rxSt <= RX_IDLE; rxCnt <= '0;
      rxDiv <= '0; rxBit <= '0; rxShift <= '0; rxValidQ <= 1'b0;
    end else begin
      rxSync   <= {rxSync[0], rxd};
      rxPrev   <= rxSync[1];
      rxValidQ <= 1'b0;
      case (rxSt)
        RX_IDLE: if (cmd.rxArm && rxPrev && !rxSync[1]) begin
          rxSt  <= RX_START;
          rxCnt <= '0;
          rxDiv <= divisor;
        end
        RX_START: if (rxCnt == (rxDiv >> 1) - 1'b1) begin
          rxCnt <= '0;
          rxBit <= '0;
          rxSt  <= rxSync[1] ? RX_IDLE : RX_DATA;
        end else rxCnt <= rxCnt + 1'b1;
        RX_DATA: if (rxCnt == rxDiv - 1'b1) begin
          rxCnt   <= '0;
          rxShift <= {rxSync[1], rxShift[DATA_W-1:1]};
          rxBit   <= rxBit + 1'b1;
          if (rxBit == BIT_W'(DATA_W - 1)) rxSt <= RX_STOP;
        end else rxCnt <= rxCnt + 1'b1;
        RX_STOP: if (rxCnt == rxDiv - 1'b1) begin
          rxCnt    <= '0;
          rxValidQ <= rxSync[1];
          rxSt     <= RX_IDLE;
        end else rxCnt <= rxCnt + 1'b1;
        default: rxSt <= RX_IDLE;
      endcase
    end
  end

  assign evt.rxValid = rxValidQ;
  assign evt.rxByte  = rxShift;
endmodule

// File: rtl/apb_byte_uart.sv
module apb_byte_uart
  import ubu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_tx_ovr,
  output logic              irq_rx_ovr,
  output logic              irq_any
);
  dpCmd_t           cmd;
  dpEvt_t           evt;
  logic [DIV_W-1:0] divisor;
  logic [3:0]       stateBits;
  logic [6:0]       ctrlBits;
  logic [3:0]       intBits;

  ubu_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .evt(evt), .cmd(cmd), .divisor(divisor), .stateBits(stateBits),
    .ctrlBits(ctrlBits), .intBits(intBits)
  );

  ubu_dp u_dp (
    .clk(pclk), .rstN(presetn), .cmd(cmd), .divisor(divisor),
    .rxd(rxd), .txd(txd), .evt(evt)
  );

  assign pready     = 1'b1;
  assign pslverr    = 1'b0;
  assign irq_tx     = intBits[0];
  assign irq_rx     = intBits[1];
  assign irq_tx_ovr = intBits[2];
  assign irq_rx_ovr = intBits[3];
  assign irq_any    = |intBits;
endmodule

// File: rtl/apb_byte_uart_chk.sv
module apb_byte_uart_chk #(
  parameter int ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              txd,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              irq_tx_ovr,
  input logic              irq_rx_ovr,
  input logic              irq_any,
  input logic [3:0]        stateBits,
  input logic [6:0]        ctrlBits
);
  logic wrAcc;
  assign wrAcc = psel && penable && pwrite;

  p_ovr_on_full_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (wrAcc && paddr == ADDR_W'(0) && stateBits[0]) |=> stateBits[2]);

  p_line_idle_r5: assert property (@(posedge pclk) disable iff (!presetn)
    !stateBits[0] |-> txd);

  p_ovr_irq_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (irq_rx_ovr == (stateBits[3] && ctrlBits[5])) &&
    (irq_tx_ovr == (stateBits[2] && ctrlBits[4])));

  p_int_clr_ovr_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (wrAcc && paddr == ADDR_W'(12) && pwdata[2]) |=> !stateBits[2]);

  p_state_clr_r13: assert property (@(posedge pclk) disable iff (!presetn)
    (wrAcc && paddr == ADDR_W'(4) && pwdata[2]) |=> !stateBits[2]);

  p_unmapped_zero_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr == ADDR_W'(32'h20)) |-> prdata == 32'h0);

  p_irq_any_r11: assert property (@(posedge pclk) disable iff (!presetn)
    irq_any == (irq_tx || irq_rx || irq_tx_ovr || irq_rx_ovr));
endmodule

bind apb_byte_uart apb_byte_uart_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_tx_ovr(irq_tx_ovr),
  .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any), .stateBits(stateBits),
  .ctrlBits(ctrlBits)
);

// File: tb/sim_apb_byte_uart.sv
module sim_apb_byte_uart;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic pclk = 1'b0, presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, rxd = 1'b1, txd;
  logic irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any;

  int vectors = 0, miscompares = 0;
  int curDiv = 16;
  bit finished = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_byte_uart u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_tx_ovr(irq_tx_ovr),
    .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any)
  );

  function automatic logic [31:0] expId(input int i);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8,
                           8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'h0, t[i]};
  endfunction
  function automatic logic [31:0] expCtrl(input logic [31:0] w);
    return w & 32'h7F;
  endfunction
  function automatic logic [31:0] expDiv(input logic [31:0] w);
    return w & 32'hFFFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic setDiv(input int d);
    curDiv = d;
    apbWrite(12'h010, d);
  endtask

  // decode one frame from txd; ok=0 if no start bit within limit
  task automatic grabTx(input int limit, output logic [7:0] b, output bit ok);
    int waited = 0;
    ok = 0; b = '0;
    while (txd !== 1'b0 && waited < limit) begin @(negedge pclk); waited++; end
    if (txd !== 1'b0) return;
    repeat (curDiv / 2) @(negedge pclk);
    if (txd !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin
      repeat (curDiv) @(negedge pclk);
      b[i] = txd;
    end
    repeat (curDiv) @(negedge pclk);
    ok = (txd === 1'b1);
    repeat (curDiv) @(negedge pclk);
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge pclk); rxd = 0;
    repeat (curDiv) @(negedge pclk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (curDiv) @(negedge pclk);
    end
    rxd = 1;
    repeat (curDiv + 4) @(negedge pclk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge pclk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] b, b2;
    bit ok;
    int highViol;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      apbRead(12'(a * 4), r);
      check("R1 reg after reset", r, 32'h0);
    end
    check("R1 txd idle", {31'h0, txd}, 32'h1);
    check("R1 irqs low", {27'h0, irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any}, 32'h0);

    // R2 control width
    apbWrite(12'h008, 32'hFFFF_FFFF);
    apbRead(12'h008, r);
    check("R2 ctrl mask", r, expCtrl(32'hFFFF_FFFF));
    apbWrite(12'h008, 32'h0);

    // R4 divisor width
    apbWrite(12'h010, 32'hFFFF_FFFF);
    apbRead(12'h010, r);
    check("R4 divisor mask", r, expDiv(32'hFFFF_FFFF));

    // R3 id words, write ignored, unmapped reads
    apbWrite(12'hFE0, 32'hDEAD_BEEF);
    for (int i = 0; i < 12; i++) begin
      apbRead(12'(12'hFD0 + i * 4), r);
      check("R3 id word", r, expId(i));
    end
    apbRead(12'h020, r);
    check("R3 unmapped read", r, 32'h0);
    apbRead(12'h800, r);
    check("R3 unmapped read", r, 32'h0);

    // R7 invalid divisor blocks transmission
    setDiv(8);
    apbWrite(12'h008, 32'h1);
    apbWrite(12'h000, 32'h5A);
    highViol = 0;
    repeat (400) begin @(negedge pclk); if (txd !== 1'b1) highViol++; end
    check("R7 txd held high", highViol, 0);
    apbRead(12'h004, r);
    check("R7 byte still pending", r & 32'h1, 32'h1);
    setDiv(16);
    grabTx(200, b, ok);
    check("R7 frame after valid divisor", {23'h0, ok, b}, {23'h0, 1'b1, 8'h5A});

    // R5 + R11 tx frame with interrupt
    apbWrite(12'h008, 32'h5);
    apbWrite(12'h000, 32'hC3);
    apbRead(12'h004, r);
    check("R5 tx full set", r & 32'h1, 32'h1);
    grabTx(200, b, ok);
    check("R5 tx frame", {23'h0, ok, b}, {23'h0, 1'b1, 8'hC3});
    apbRead(12'h004, r);
    check("R5 tx full cleared", r & 32'h1, 32'h0);
    apbRead(12'h00C, r);
    check("R11 tx int set", r, 32'h1);
    check("R11 irq lines", {30'h0, irq_tx, irq_any}, 32'h3);
    apbWrite(12'h00C, 32'h1);
    apbRead(12'h00C, r);
    check("R11 tx int cleared", r, 32'h0);

    // R11 tx int not set when disabled
    apbWrite(12'h008, 32'h1);
    apbWrite(12'h000, 32'h11);
    grabTx(200, b, ok);
    apbRead(12'h00C, r);
    check("R11 tx int masked", r, 32'h0);

    // R6 + R12 tx overrun while transmit disabled
    apbWrite(12'h008, 32'h10);
    apbWrite(12'h000, 32'hA5);
    apbWrite(12'h000, 32'h3C);
    apbRead(12'h004, r);
    check("R6 tx overrun flag", r & 32'h5, 32'h5);
    apbRead(12'h00C, r);
    check("R12 tx overrun int", r, 32'h4);
    check("R12 irq lines", {30'h0, irq_tx_ovr, irq_any}, 32'h3);
    apbWrite(12'h008, 32'h0);
    apbRead(12'h00C, r);
    check("R12 overrun int gated", r, 32'h0);
    apbRead(12'h004, r);
    check("R12 flag survives gating", r & 32'h4, 32'h4);
    apbWrite(12'h008, 32'h10);
    apbWrite(12'h00C, 32'h4);
    apbRead(12'h004, r);
    check("R12 int clear clears flag", r & 32'h4, 32'h0);
    apbWrite(12'h008, 32'h1);
    grabTx(200, b, ok);
    check("R6 first byte kept", {23'h0, ok, b}, {23'h0, 1'b1, 8'hA5});

    // R8 + R11 receive with interrupt
    apbWrite(12'h008, 32'h0A);
    sendRx(8'h96);
    apbRead(12'h004, r);
    check("R8 rx full", r & 32'h2, 32'h2);
    check("R11 irq_rx", {31'h0, irq_rx}, 32'h1);
    apbRead(12'h000, r);
    check("R8 rx data", r, 32'h96);
    apbRead(12'h004, r);
    check("R8 rx full cleared", r & 32'h2, 32'h0);
    apbWrite(12'h00C, 32'h2);
    apbRead(12'h00C, r);
    check("R11 rx int cleared", r, 32'h0);

    // R9 + R12 + R13 receive overrun
    apbWrite(12'h008, 32'h22);
    sendRx(8'h12);
    sendRx(8'h34);
    apbRead(12'h004, r);
    check("R9 rx overrun flag", r & 32'hA, 32'hA);
    apbRead(12'h00C, r);
    check("R12 rx overrun int", r, 32'h8);
    apbRead(12'h000, r);
    check("R9 newer byte kept", r, 32'h34);
    apbWrite(12'h004, 32'h0);
    apbRead(12'h004, r);
    check("R13 zero write keeps flag", r & 32'h8, 32'h8);
    apbWrite(12'h004, 32'h8);
    apbRead(12'h004, r);
    check("R13 flag cleared", r & 32'h8, 32'h0);
    check("R13 irq cleared", {31'h0, irq_any}, 32'h0);

    // R10 receive disabled
    apbWrite(12'h008, 32'h0);
    sendRx(8'h77);
    apbRead(12'h004, r);
    check("R10 rx ignored", r & 32'h2, 32'h0);

    // random loop: R5 and R8 across divisors and bytes
    for (int it = 0; it < 10; it++) begin
      int d;
      d = 16 + int'($urandom_range(0, 15));
      setDiv(d);
      apbWrite(12'h008, 32'h3);
      b = 8'($urandom());
      b2 = 8'($urandom());
      apbWrite(12'h000, {24'h0, b});
      grabTx(300, r[7:0], ok);
      check("R5 random tx", {23'h0, ok, r[7:0]}, {23'h0, 1'b1, b});
      sendRx(b2);
      apbRead(12'h000, r);
      check("R8 random rx", r, {24'h0, b2});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule